// File: doc/BRIEF.md
# Cascaded Two-Line Delay Memory

This block holds two equal-depth line memories, each twelve bits wide, that are accessed in strict address order and chained one behind the other. An external writer fills the first memory through its own clock, an active-low write enable and an active-low address clear. A single read port, which runs on a second clock, reads both memories at once. On every enabled read edge the word leaving the first memory is also stored into the second memory. The block therefore presents two streams at the same time: one is one line old and the other is two lines old.

The second memory has no control pins of its own. The read clock, read enable and read clear of the first memory also run its write and read counters. A video-style line filter can then take the current line, the previous line and the line before that from one part, with no outside loop-back wiring. When reading is disabled, all output pins float.

Top module: `line_delay_cascade`

## Requirements
- R1: On a rising `wr_clk` edge with `wr_rst_n` high and `wr_en_n` low, the input word is stored in memory A at its write address, and that address advances by one.
- R2: On a rising `wr_clk` edge with `wr_rst_n` high and `wr_en_n` high, memory A is not written and its write address holds its value.
- R3: On a rising `wr_clk` edge with `wr_rst_n` low, memory A's write address becomes 0 and nothing is stored, even if `wr_en_n` is low.
- R4: On a rising `rd_clk` edge with `rd_rst_n` high and `rd_en_n` low, the word at memory A's read address is registered to the first output, and that read address advances by one.
- R5: On that same edge, the word read from A is written into memory B at B's write address. B's read address always equals its write address, so B's output is the word B held before this write. B's write and read addresses both advance.
- R6: On a rising `rd_clk` edge with `rd_rst_n` high and `rd_en_n` high, neither memory is read, B is not written, and A's read address and both of B's addresses hold their values.
- R7: While `rd_en_n` is high, `q_first`, `q_mixed` and `q_second` are all high impedance.
- R8: On a rising `rd_clk` edge with `rd_rst_n` low, A's read address and both of B's addresses become 0, and no read or copy takes place, even if `rd_en_n` is low.
- R9: Bits 11..4 of the stored word come from `din_hi` and bits 3..0 come from `din_lo[3:0]`. `din_lo[7:4]` is ignored. The word from A appears as {`q_first`, `q_mixed[3:0]`} and the word from B appears as {`q_second`, `q_mixed[7:4]`}.
- R10: Every address advances from DEPTH-1 to 0.
- R11: If both clears are pulsed together before each line of DEPTH enabled cycles, the A output during line L is line L-1 at the same position, and the B output is line L-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock for memory A |
| wr_en_n | input | 1 | Active-low write enable for memory A |
| wr_rst_n | input | 1 | Active-low synchronous clear of A's write address |
| din_hi | input | 8 | Input word bits 11..4 |
| din_lo | input | 8 | Input word bits 3..0 in the low nibble; upper nibble ignored |
| rd_clk | input | 1 | Read-side clock for both memories |
| rd_en_n | input | 1 | Active-low read/copy enable; high floats all outputs |
| rd_rst_n | input | 1 | Active-low synchronous clear of A's read address and both of B's addresses |
| q_first | output | 8 | Memory A word bits 11..4 |
| q_mixed | output | 8 | Low nibble: A bits 3..0; high nibble: B bits 3..0 |
| q_second | output | 8 | Memory B word bits 11..4 |

## Verification
A wrong address in memory A shows up on the first read after it: the A output carries a word from the wrong line position, or from the wrong line. Counters that fail to hold during a pause, or fail to wrap, shift every later word by a fixed offset. A fault in B's copy path or in B's address pair shows up one line later, as a two-line output that does not match the word the A output showed one line earlier at the same position. A wrong output enable shows up in the same cycle as a driven value while reading is disabled.

// File: rtl/ldly_pkg.sv
// Package: shared word type and field split for the two-line delay.
// Assumes a fixed 12-bit word made of one byte and one nibble.
package ldly_pkg;

    localparam int WORD_W = 12;
    localparam int HI_W   = 8;
    localparam int NIB_W  = WORD_W - HI_W;

    typedef logic [WORD_W-1:0] word_t;

    // Build a stored word from the byte bus and a nibble.
    function automatic word_t join_word(input logic [HI_W-1:0] hi,
                                        input logic [NIB_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/ldly_addr_ctr.sv
// Sequential address counter with synchronous active-low clear.
// Clear has priority over step; wraps from DEPTH-1 to 0.
// Assumes DEPTH >= 2.
module ldly_addr_ctr #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          step,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Clear, advance with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            addr <= '0;
        end else if (step) begin
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
        end
    end

endmodule

// File: rtl/ldly_line_ram.sv
// One line memory: write port and registered read port on separate clocks.
// Also exposes the word at the read address combinationally, so that a
// following stage can store it on the same edge that registers it here.
// Read and write on one clock and one address return the old contents.
module ldly_line_ram
    import ldly_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          wr_clk,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic          rd_clk,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_peek,
    output word_t         rd_data
);

    word_t mem [DEPTH];

    // Store the incoming word when the write side is enabled.
    always_ff @(posedge wr_clk) begin
        if (wr_go) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Word currently addressed by the read side.
    assign rd_peek = mem[rd_addr];

    // Register the addressed word when the read side is enabled.
    always_ff @(posedge rd_clk) begin
        if (rd_go) begin
            rd_data <= rd_peek;
        end
    end

endmodule

// File: rtl/ldly_out_drv.sv
// Tri-state output driver: floats when the active-low enable is high.
module ldly_out_drv #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] d,
    output wire  [W-1:0] q
);

    // Drive the data or release the pins.
    assign q = oe_n ? {W{1'bz}} : d;

endmodule

// File: rtl/line_delay_cascade.sv
// Top: two chained line memories giving one-line and two-line delayed data.
// Memory A: written from the write port, read by the read port.
// Memory B: written with A's read word and read on the same read-clock edge;
// its counters share the read port's clear and enable.
// Assumes wr_clk and rd_clk are free-running; no full/empty tracking.
module line_delay_cascade
    import ldly_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       wr_clk,
    input  logic       wr_en_n,
    input  logic       wr_rst_n,
    input  logic [7:0] din_hi,
    input  logic [7:0] din_lo,
    input  logic       rd_clk,
    input  logic       rd_en_n,
    input  logic       rd_rst_n,
    output wire  [7:0] q_first,
    output wire  [7:0] q_mixed,
    output wire  [7:0] q_second
);

    word_t          in_word;
    logic           wr_go_a;
    logic           rd_go;
    logic [AW-1:0]  wr_addr_a;
    logic [AW-1:0]  rd_addr_a;
    logic [AW-1:0]  wr_addr_b;
    logic [AW-1:0]  rd_addr_b;
    word_t          a_peek;
    word_t          word_a_q;
    word_t          word_b_q;
    word_t          unused_peek_b;
    logic           unused_hi_nib;

    // Assemble the stored word; the upper nibble of din_lo is discarded.
    assign in_word       = join_word(din_hi, din_lo[NIB_W-1:0]);
    assign unused_hi_nib = ^din_lo[7:NIB_W];

    // Enables gated by clears: a clear cycle never moves data.
    assign wr_go_a = wr_rst_n && !wr_en_n;
    assign rd_go   = rd_rst_n && !rd_en_n;

    ldly_addr_ctr #(.DEPTH(DEPTH)) u_wa (
        .clk   (wr_clk),
        .clr_n (wr_rst_n),
        .step  (wr_go_a),
        .addr  (wr_addr_a)
    );

    ldly_addr_ctr #(.DEPTH(DEPTH)) u_ra (
        .clk   (rd_clk),
        .clr_n (rd_rst_n),
        .step  (rd_go),
        .addr  (rd_addr_a)
    );

    ldly_addr_ctr #(.DEPTH(DEPTH)) u_wb (
        .clk   (rd_clk),
        .clr_n (rd_rst_n),
        .step  (rd_go),
        .addr  (wr_addr_b)
    );

    ldly_addr_ctr #(.DEPTH(DEPTH)) u_rb (
        .clk   (rd_clk),
        .clr_n (rd_rst_n),
        .step  (rd_go),
        .addr  (rd_addr_b)
    );

    ldly_line_ram #(.DEPTH(DEPTH)) u_mem_a (
        .wr_clk  (wr_clk),
        .wr_go   (wr_go_a),
        .wr_addr (wr_addr_a),
        .wr_data (in_word),
        .rd_clk  (rd_clk),
        .rd_go   (rd_go),
        .rd_addr (rd_addr_a),
        .rd_peek (a_peek),
        .rd_data (word_a_q)
    );

    ldly_line_ram #(.DEPTH(DEPTH)) u_mem_b (
        .wr_clk  (rd_clk),
        .wr_go   (rd_go),
        .wr_addr (wr_addr_b),
        .wr_data (a_peek),
        .rd_clk  (rd_clk),
        .rd_go   (rd_go),
        .rd_addr (rd_addr_b),
        .rd_peek (unused_peek_b),
        .rd_data (word_b_q)
    );

    ldly_out_drv #(.W(HI_W)) u_drv_first (
        .oe_n (rd_en_n),
        .d    (word_a_q[WORD_W-1:NIB_W]),
        .q    (q_first)
    );

    ldly_out_drv #(.W(HI_W)) u_drv_mixed (
        .oe_n (rd_en_n),
        .d    ({word_b_q[NIB_W-1:0], word_a_q[NIB_W-1:0]}),
        .q    (q_mixed)
    );

    ldly_out_drv #(.W(HI_W)) u_drv_second (
        .oe_n (rd_en_n),
        .d    (word_b_q[WORD_W-1:NIB_W]),
        .q    (q_second)
    );

endmodule

// File: rtl/ldly_chk.sv
// Checker for line_delay_cascade: address counter behaviour on both clocks.
// Arms itself per clock domain once that domain's clear has been seen.
module ldly_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          wr_clk,
    input logic          wr_en_n,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_en_n,
    input logic          rd_rst_n,
    input logic [AW-1:0] wr_addr_a,
    input logic [AW-1:0] rd_addr_a,
    input logic [AW-1:0] wr_addr_b,
    input logic [AW-1:0] rd_addr_b,
    input logic [11:0]   word_a_q,
    input logic [11:0]   word_b_q
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic w_armed = 1'b0;
    logic r_armed = 1'b0;

    // Arm the write-side checks after the first write clear.
    always_ff @(posedge wr_clk) if (!wr_rst_n) w_armed <= 1'b1;

    // Arm the read-side checks after the first read clear.
    always_ff @(posedge rd_clk) if (!rd_rst_n) r_armed <= 1'b1;

    // R1
    wr_step_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        (wr_rst_n && !wr_en_n && wr_addr_a != LAST) |=> wr_addr_a == $past(wr_addr_a) + 1'b1);

    // R2
    wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        (wr_rst_n && wr_en_n) |=> $stable(wr_addr_a));

    // R3
    wr_clear_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        !wr_rst_n |=> wr_addr_a == '0);

    // R10
    wr_wrap_chk: assert property (@(posedge wr_clk) disable iff (!w_armed)
        (wr_rst_n && !wr_en_n && wr_addr_a == LAST) |=> wr_addr_a == '0);

    // R4
    rd_step_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        (rd_rst_n && !rd_en_n && rd_addr_a != LAST) |=> rd_addr_a == $past(rd_addr_a) + 1'b1);

    // R10
    rd_wrap_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        (rd_rst_n && !rd_en_n && rd_addr_a == LAST) |=> rd_addr_a == '0);

    // R5
    b_lockstep_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        wr_addr_b == rd_addr_b);

    // R6
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        (rd_rst_n && rd_en_n) |=> $stable(rd_addr_a) && $stable(wr_addr_b)
                                  && $stable(word_a_q) && $stable(word_b_q));

    // R8
    rd_clear_chk: assert property (@(posedge rd_clk) disable iff (!r_armed)
        !rd_rst_n |=> rd_addr_a == '0 && wr_addr_b == '0 && rd_addr_b == '0
                      && $stable(word_a_q) && $stable(word_b_q));

endmodule

bind line_delay_cascade ldly_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .wr_en_n   (wr_en_n),
    .wr_rst_n  (wr_rst_n),
    .rd_clk    (rd_clk),
    .rd_en_n   (rd_en_n),
    .rd_rst_n  (rd_rst_n),
    .wr_addr_a (wr_addr_a),
    .rd_addr_a (rd_addr_a),
    .wr_addr_b (wr_addr_b),
    .rd_addr_b (rd_addr_b),
    .word_a_q  (word_a_q),
    .word_b_q  (word_b_q)
);

// File: tb/line_delay_cascade_test.sv
// Bench: behavioural model with integer arrays, compared every read clock.
module line_delay_cascade_test;

    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       wr_en_n  = 1'b1;
    logic       wr_rst_n = 1'b1;
    logic       rd_en_n  = 1'b1;
    logic       rd_rst_n = 1'b1;
    logic [7:0] din_hi   = 8'h00;
    logic [7:0] din_lo   = 8'h00;
    tri1  [7:0] q_first;
    tri1  [7:0] q_mixed;
    tri1  [7:0] q_second;

    line_delay_cascade #(.DEPTH(DEPTH)) uut (
        .wr_clk   (clk),
        .wr_en_n  (wr_en_n),
        .wr_rst_n (wr_rst_n),
        .din_hi   (din_hi),
        .din_lo   (din_lo),
        .rd_clk   (clk),
        .rd_en_n  (rd_en_n),
        .rd_rst_n (rd_rst_n),
        .q_first  (q_first),
        .q_mixed  (q_mixed),
        .q_second (q_second)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int ramp(input int line, input int i);
        return (line * 256 + i * 3 + 1) & 12'hFFF;
    endfunction

    // Reference model state: -1 marks an unknown word.
    int ma [DEPTH];
    int mb [DEPTH];
    int wa = 0, ra = 0, rb = 0;
    int exp_a = -1, exp_b = -1;

    initial begin
        foreach (ma[k]) begin ma[k] = -1; mb[k] = -1; end
    end

    // Model update: read side first (sees old A contents), then write side.
    always @(posedge clk) begin : model
        int va, vb;
        if (!rd_rst_n) begin
            ra = 0; rb = 0;
        end else if (!rd_en_n) begin
            va = ma[ra]; vb = mb[rb];
            mb[rb] = va;
            exp_a = va; exp_b = vb;
            ra = (ra + 1) % DEPTH; rb = (rb + 1) % DEPTH;
        end
        if (!wr_rst_n) begin
            wa = 0;
        end else if (!wr_en_n) begin
            ma[wa] = {din_hi, din_lo[3:0]};
            wa = (wa + 1) % DEPTH;
        end
    end

    // Every-cycle comparison, away from both clock edges.
    always @(posedge clk) begin
        #2;
        if (rd_en_n) begin
            chk("R7 q_first float", q_first, 8'hFF);
            chk("R7 q_mixed float", q_mixed, 8'hFF);
            chk("R7 q_second float", q_second, 8'hFF);
        end else begin
            if (exp_a >= 0) chk("R4 R9 A word", {q_first, q_mixed[3:0]}, exp_a);
            if (exp_b >= 0) chk("R5 R9 B word", {q_second, q_mixed[7:4]}, exp_b);
        end
    end

    // One cycle: drive at the falling edge, return just after the rising edge.
    task automatic cyc(input bit we_n, input bit wr_n, input bit re_n, input bit rr_n, input int w);
        @(negedge clk);
        wr_en_n  = we_n;
        wr_rst_n = wr_n;
        rd_en_n  = re_n;
        rd_rst_n = rr_n;
        din_hi   = w[11:4];
        din_lo   = {w[7:4] ^ 4'hA, w[3:0]};
        @(posedge clk);
        #2;
    endtask

    task automatic line_checks(input int line, input int i);
        if (line >= 1) chk("R11 R1 one-line delay", {q_first, q_mixed[3:0]}, ramp(line - 1, i));
        if (line >= 2) chk("R11 R5 two-line delay", {q_second, q_mixed[7:4]}, ramp(line - 2, i));
    endtask

    initial begin
        repeat (3) cyc(1, 1, 1, 1, 0);
        cyc(1, 0, 1, 0, 0);
        // Line 0: write only, outputs float (R7).
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 1, 1, ramp(0, i));
        // R3 R8: clears win over low enables; this word must never appear.
        cyc(0, 0, 0, 0, ramp(9, 0));
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 0, 1, ramp(1, i));
            line_checks(1, i);
        end
        cyc(1, 0, 1, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 0, 1, ramp(2, i));
            line_checks(2, i);
        end
        // Line 3: no clear, counters wrap (R10); pause mid-line (R2 R6).
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 8) repeat (3) cyc(1, 1, 1, 1, ramp(15, 0));
            cyc(0, 1, 0, 1, ramp(3, i));
            line_checks(3, i);
        end
        cyc(1, 0, 1, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 0, 1, ramp(4, i));
            line_checks(4, i);
        end
        // Reads continue while writes pause: model-only comparison (R2 R4).
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 1, ramp(14, i));
        cyc(1, 1, 1, 1, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule